// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Controller

This block sits between a synchronous host and a 2M x 8 asynchronous static RAM. The host hands over one request at a time through a valid/ready handshake: a write flag, a 21-bit byte address and, for writes, one data byte. The controller turns each request into a timed sequence of the RAM's active-low chip select, output enable and write enable. It then raises a one-cycle done pulse, which carries the captured byte when the request was a read.

Every analogue interval of the RAM (access times, write pulse width, data setup, write recovery, output float delay) is a parameter in nanoseconds, as is the clock period. The controller turns each interval into a whole number of clock cycles when it elaborates, so one netlist serves any speed grade. Write enable takes priority over output enable: output enable stays high for the whole of every write. The controller switches its own data drivers on only when the RAM can no longer be driving the shared bus. The tri-state buffer sits outside the block, which has a separate data-out, data-out-enable and data-in.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select, output enable and write enable are all 1, the data-out enable is 0, ready is 1 and done is 0.
- R2: Strobe encoding. A write has chip select 0, write enable 0 and output enable 1. A read has chip select 0, output enable 0 and write enable 1. Idle has all three at 1. Write enable and output enable are never 0 together, and write enable is 0 only while chip select is 0.
- R3: A read accepted on clock edge E holds chip select 0 from E. It drops output enable at E+1 and keeps it 0 through the read-wait interval. On the last cycle of that interval it captures the bus and raises done for exactly one cycle, with the byte, after edge E+7 at default parameters.
- R4: A write accepted on edge E drives the data bus and chip select from E. It holds write enable 0 for the write-pulse interval starting at E+1, then keeps the address, data and chip select for the recovery interval. At the end it releases them and raises done for one cycle, after edge E+7 at default parameters.
- R5: After a read, chip select and output enable go high with done, and ready stays 0 for the turnaround interval (3 cycles at defaults). The data-out enable is never 1 while output enable is 0, nor within the float delay after output enable rises.
- R6: A request is taken only on an edge where valid and ready are both 1. Ready is 0 from acceptance until the operation has ended. Inputs seen while valid is 0 start nothing.
- R7: The RAM address equals the accepted request address, and stays constant for as long as chip select is 0.
- R8: Each interval is max(1, ceil(ns / period)). Setup is 1 cycle. Read wait is the largest of the output-enable access, the address access minus setup, and the read cycle minus setup. Write pulse is the largest of the pulse width, the data setup, the chip-select-to-end minus setup, the address-to-end minus setup, and the write cycle minus setup and recovery. Recovery is the larger of write recovery and data hold. Turnaround is the larger of the two float delays. Defaults (10 ns clock, 70 ns grade) give 1, 6, 5, 1 and 3 cycles.
- R9: Any 21-bit address reaches the RAM unchanged, including all four values of bits 20:19, which the RAM decodes into its four 512K banks. The lowest and highest addresses are included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte, valid with done after a read |
| ram_addr | output | 21 | RAM address lines |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | 8 | Byte to drive onto the RAM data bus |
| ram_dq_oe | output | 1 | Enable for the external data bus drivers |
| ram_dq_in | input | 8 | Byte read from the RAM data bus |

## Verification
The bench hangs a timed RAM model on the pins. The model returns the inverted byte if it is sampled before the access times have run out, so a controller that captures one cycle early returns wrong data. The model also flags a write whose pulse, data setup or chip-select window is short, and it flags contention when the controller drives the bus during output enable or within the float delay after it. A controller that skipped the turnaround would therefore fail a write that follows a read at once. Back-to-back mixes of reads and writes, the extreme addresses and all four bank selects catch a wrong handshake, a lost write or a bank bit that is truncated.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_READ_WAIT,
    ST_WRITE_PULSE,
    ST_HOLD,
    ST_TURN
  } seq_state_t;

  // whole cycles covering t_ns, never fewer than one
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned period_ns);
    int unsigned c;
    c = (t_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // interval remaining once some cycles are already spent, at least one
  function automatic int unsigned less_spent(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 1;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned AS_CYC   = 1,
  parameter int unsigned RD_CYC   = 6,
  parameter int unsigned WP_CYC   = 5,
  parameter int unsigned HOLD_CYC = 1,
  parameter int unsigned TA_CYC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             timer_expired,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             idle,
  output logic             accept_evt,
  output logic             capture_evt,
  output logic             write_end_evt,
  output logic             cs_n,
  output logic             oe_n,
  output logic             we_n,
  output logic             dq_drive,
  output logic             done
);
  seq_state_t state_q, state_d;
  logic       is_write_q;
  logic       write_sel;

  assign write_sel = (state_q == ST_IDLE) ? req_write : is_write_q;

  always_comb begin
    state_d       = state_q;
    timer_load    = 1'b0;
    timer_val     = '0;
    accept_evt    = 1'b0;
    capture_evt   = 1'b0;
    write_end_evt = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept_evt = 1'b1;
        state_d    = ST_SETUP;
        timer_load = 1'b1;
        timer_val  = CNT_W'(AS_CYC - 1);
      end
      ST_SETUP: if (timer_expired) begin
        state_d    = is_write_q ? ST_WRITE_PULSE : ST_READ_WAIT;
        timer_load = 1'b1;
        timer_val  = is_write_q ? CNT_W'(WP_CYC - 1) : CNT_W'(RD_CYC - 1);
      end
      ST_READ_WAIT: if (timer_expired) begin
        capture_evt = 1'b1;
        state_d     = ST_TURN;
        timer_load  = 1'b1;
        timer_val   = CNT_W'(TA_CYC - 1);
      end
      ST_WRITE_PULSE: if (timer_expired) begin
        state_d    = ST_HOLD;
        timer_load = 1'b1;
        timer_val  = CNT_W'(HOLD_CYC - 1);
      end
      ST_HOLD: if (timer_expired) begin
        write_end_evt = 1'b1;
        state_d       = ST_IDLE;
      end
      ST_TURN: if (timer_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      is_write_q <= 1'b0;
      cs_n       <= 1'b1;
      oe_n       <= 1'b1;
      we_n       <= 1'b1;
      dq_drive   <= 1'b0;
      done       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_evt) is_write_q <= req_write;
      // strobes are registered from the next state so they leave flops directly
      cs_n     <= !(state_d inside {ST_SETUP, ST_READ_WAIT, ST_WRITE_PULSE, ST_HOLD});
      oe_n     <= !(state_d == ST_READ_WAIT);
      we_n     <= !(state_d == ST_WRITE_PULSE);
      dq_drive <= write_sel && (state_d inside {ST_SETUP, ST_WRITE_PULSE, ST_HOLD});
      done     <= capture_evt || write_end_evt;
    end
  end

  assign idle = (state_q == ST_IDLE);
endmodule

// File: rtl/sram_data_path.sv
`timescale 1ns/1ps
module sram_data_path #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_evt,
  input  logic              capture_evt,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (accept_evt) begin
        ram_addr   <= req_addr;
        ram_dq_out <= req_wdata;
      end
      if (capture_evt) rsp_rdata <= ram_dq_in;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 21,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_RC_NS       = 70,
  parameter int unsigned T_AA_NS       = 70,
  parameter int unsigned T_OE_NS       = 40,
  parameter int unsigned T_WC_NS       = 70,
  parameter int unsigned T_WP_NS       = 50,
  parameter int unsigned T_CW_NS       = 60,
  parameter int unsigned T_AW_NS       = 60,
  parameter int unsigned T_AS_NS       = 0,
  parameter int unsigned T_WR_NS       = 5,
  parameter int unsigned T_DW_NS       = 30,
  parameter int unsigned T_DH_NS       = 0,
  parameter int unsigned T_OHZ_NS      = 25,
  parameter int unsigned T_CHZ_NS      = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_in
);
  localparam int unsigned P        = CLK_PERIOD_NS;
  localparam int unsigned AS_CYC   = ns_to_cycles(T_AS_NS, P);
  localparam int unsigned RD_CYC   = max_u(ns_to_cycles(T_OE_NS, P),
                                       max_u(less_spent(ns_to_cycles(T_AA_NS, P), AS_CYC),
                                             less_spent(ns_to_cycles(T_RC_NS, P), AS_CYC)));
  localparam int unsigned HOLD_CYC = max_u(ns_to_cycles(T_WR_NS, P), ns_to_cycles(T_DH_NS, P));
  localparam int unsigned WP_CYC   = max_u(max_u(ns_to_cycles(T_WP_NS, P), ns_to_cycles(T_DW_NS, P)),
                                       max_u(less_spent(ns_to_cycles(T_CW_NS, P), AS_CYC),
                                         max_u(less_spent(ns_to_cycles(T_AW_NS, P), AS_CYC),
                                               less_spent(ns_to_cycles(T_WC_NS, P), AS_CYC + HOLD_CYC))));
  localparam int unsigned TA_CYC   = max_u(ns_to_cycles(T_OHZ_NS, P), ns_to_cycles(T_CHZ_NS, P));
  localparam int unsigned MAX_CYC  = max_u(max_u(AS_CYC, RD_CYC), max_u(max_u(WP_CYC, HOLD_CYC), TA_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  // named internal events, observed by the bound checker
  logic             accept_evt;
  logic             capture_evt;
  logic             write_end_evt;
  logic             timer_expired;
  logic             timer_load;
  logic [CNT_W-1:0] timer_val;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expired  (timer_expired)
  );

  sram_seq_fsm #(
    .CNT_W    (CNT_W),
    .AS_CYC   (AS_CYC),
    .RD_CYC   (RD_CYC),
    .WP_CYC   (WP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .TA_CYC   (TA_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .timer_expired (timer_expired),
    .timer_load    (timer_load),
    .timer_val     (timer_val),
    .idle          (req_ready),
    .accept_evt    (accept_evt),
    .capture_evt   (capture_evt),
    .write_end_evt (write_end_evt),
    .cs_n          (ram_cs_n),
    .oe_n          (ram_oe_n),
    .we_n          (ram_we_n),
    .dq_drive      (ram_dq_oe),
    .done          (rsp_done)
  );

  sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_evt  (accept_evt),
    .capture_evt (capture_evt),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ram_dq_in   (ram_dq_in),
    .ram_addr    (ram_addr),
    .ram_dq_out  (ram_dq_out),
    .rsp_rdata   (rsp_rdata)
  );
endmodule

// File: rtl/sram_ctrl_checker.sv
`timescale 1ns/1ps
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned TA_CYC = 3,
  parameter int unsigned WP_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ram_cs_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic              ram_dq_oe,
  input logic              capture_evt
);
  int unsigned oe_high_run;
  int unsigned we_low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_high_run <= TA_CYC;
      we_low_run  <= 0;
    end else begin
      if (!ram_oe_n)                oe_high_run <= 0;
      else if (oe_high_run < TA_CYC) oe_high_run <= oe_high_run + 1;
      we_low_run <= ram_we_n ? 0 : we_low_run + 1;
    end
  end

  assert_we_beats_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_cs_n && ram_oe_n));

  assert_capture_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |-> (!ram_oe_n && !ram_cs_n));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_run >= WP_CYC));

  assert_no_drive_in_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> !ram_dq_oe);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> (oe_high_run >= TA_CYC));

  assert_one_in_flight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_addr_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
  .ADDR_W (ADDR_W),
  .TA_CYC (TA_CYC),
  .WP_CYC (WP_CYC)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_done    (rsp_done),
  .ram_addr    (ram_addr),
  .ram_cs_n    (ram_cs_n),
  .ram_oe_n    (ram_oe_n),
  .ram_we_n    (ram_we_n),
  .ram_dq_oe   (ram_dq_oe),
  .capture_evt (capture_evt)
);

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_RC = 70, N_AA = 70, N_OE = 40, N_WC = 70, N_WP = 50, N_CW = 60;
  localparam int N_AW = 60, N_AS = 0, N_WR = 5, N_DW = 30, N_DH = 0, N_OHZ = 25, N_CHZ = 25;

  function automatic int cyc(input int ns);
    int n = 1;
    while (n * CLK_PERIOD < ns) n++;
    return n;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_AS   = cyc(N_AS);
  localparam int B_RD   = mx(cyc(N_OE), mx(cyc(N_AA) - B_AS, cyc(N_RC) - B_AS));
  localparam int B_HOLD = mx(cyc(N_WR), cyc(N_DH));
  localparam int B_WP   = mx(mx(cyc(N_WP), cyc(N_DW)),
                             mx(cyc(N_CW) - B_AS, mx(cyc(N_AW) - B_AS, cyc(N_WC) - B_AS - B_HOLD)));
  localparam int B_TA   = mx(cyc(N_OHZ), cyc(N_CHZ));
  localparam int R_DONE = B_AS + B_RD;
  localparam int R_END  = R_DONE + B_TA;
  localparam int W_END  = B_AS + B_WP + B_HOLD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done, ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0]  rsp_rdata, ram_dq_out;
  logic [7:0]  ram_dq_in = 8'h00;
  logic [20:0] ram_addr;

  int n_checks = 0, n_fail = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_async_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD), .T_RC_NS(N_RC), .T_AA_NS(N_AA), .T_OE_NS(N_OE),
    .T_WC_NS(N_WC), .T_WP_NS(N_WP), .T_CW_NS(N_CW), .T_AW_NS(N_AW), .T_AS_NS(N_AS),
    .T_WR_NS(N_WR), .T_DW_NS(N_DW), .T_DH_NS(N_DH), .T_OHZ_NS(N_OHZ), .T_CHZ_NS(N_CHZ)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_pat(input logic [20:0] a);
    return a[7:0] ^ a[15:8] ^ {3'b000, a[20:16]} ^ 8'h3C;
  endfunction

  // ---------------- timed RAM model on the pins ----------------
  logic [7:0] ram_mem [int];
  int cs_cnt = 0, oe_cnt = 0, off_cnt = 1000, we_cnt = 0, dat_cnt = 0;
  logic [20:0] prev_addr = '0;
  logic [7:0]  prev_dout = '0;
  logic        prev_we = 1'b1;

  always @(negedge clk) begin
    bit rd_en;
    logic [7:0] v;
    rd_en = !ram_cs_n && !ram_oe_n && ram_we_n;
    if (!rst_n) begin
      cs_cnt = 0; oe_cnt = 0; off_cnt = 1000; we_cnt = 0; dat_cnt = 0;
    end else begin
      if (ram_we_n && !prev_we) begin
        check(we_cnt * CLK_PERIOD >= N_WP, "R4", "write pulse ns", we_cnt * CLK_PERIOD, N_WP);
        check(dat_cnt * CLK_PERIOD >= N_DW, "R4", "data setup ns", dat_cnt * CLK_PERIOD, N_DW);
        check(cs_cnt * CLK_PERIOD >= N_CW, "R4", "select to end ns", cs_cnt * CLK_PERIOD, N_CW);
        check(ram_dq_oe, "R4", "drivers on at write end", ram_dq_oe, 1);
        ram_mem[int'(ram_addr)] = ram_dq_out;
      end
      if (ram_cs_n) cs_cnt = 0;
      else if (cs_cnt != 0 && ram_addr != prev_addr) cs_cnt = 1;
      else cs_cnt = cs_cnt + 1;
      oe_cnt  = rd_en ? oe_cnt + 1 : 0;
      off_cnt = rd_en ? 0 : ((off_cnt < 1000) ? off_cnt + 1 : off_cnt);
      we_cnt  = ram_we_n ? 0 : we_cnt + 1;
      if (!ram_dq_oe) dat_cnt = 0;
      else if (dat_cnt != 0 && ram_dq_out == prev_dout) dat_cnt = dat_cnt + 1;
      else dat_cnt = 1;
      if (ram_dq_oe)
        check(!rd_en && (off_cnt - 1) * CLK_PERIOD >= N_OHZ, "R5", "bus contention, float ns",
              (off_cnt - 1) * CLK_PERIOD, N_OHZ);
    end
    prev_we = ram_we_n; prev_addr = ram_addr; prev_dout = ram_dq_out;
    if (rd_en) begin
      v = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : init_pat(ram_addr);
      ram_dq_in = (cs_cnt * CLK_PERIOD >= N_AA && oe_cnt * CLK_PERIOD >= N_OE) ? v : ~v;
    end else begin
      ram_dq_in = 8'h00;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [7:0]  ref_mem [int];
  bit          busy = 0, op_wr = 0, exp_done = 0;
  int          t = 0;
  logic [20:0] op_addr = '0;
  logic [7:0]  op_data = '0, exp_rdata = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 0; t <= 0; exp_done <= 0;
    end else begin
      exp_done <= 0;
      if (busy) begin
        if (t + 1 == (op_wr ? W_END : R_END)) busy <= 0;
        else t <= t + 1;
        if (op_wr && t + 1 == W_END) exp_done <= 1;
        if (!op_wr && t + 1 == R_DONE) begin
          exp_done  <= 1;
          exp_rdata <= ref_mem.exists(int'(op_addr)) ? ref_mem[int'(op_addr)] : init_pat(op_addr);
        end
      end else if (req_valid) begin
        busy <= 1; t <= 0; op_wr <= req_write; op_addr <= req_addr; op_data <= req_wdata;
        if (req_write) ref_mem[int'(req_addr)] = req_wdata;
      end
    end
  end

  always @(negedge clk) begin
    logic e_cs, e_oe, e_we, e_dq;
    if (cmp_on) begin
      if (!busy) begin
        e_cs = 1; e_oe = 1; e_we = 1; e_dq = 0;
      end else if (op_wr) begin
        e_cs = 0; e_oe = 1; e_dq = 1;
        e_we = !(t >= B_AS && t < B_AS + B_WP);
      end else begin
        e_cs = !(t < R_DONE); e_oe = !(t >= B_AS && t < R_DONE); e_we = 1; e_dq = 0;
      end
      check(ram_cs_n == e_cs, "R2", "chip select", ram_cs_n, e_cs);
      check(ram_oe_n == e_oe, "R3", "output enable", ram_oe_n, e_oe);
      check(ram_we_n == e_we, "R4", "write enable", ram_we_n, e_we);
      check(ram_dq_oe == e_dq, "R5", "data drive enable", ram_dq_oe, e_dq);
      check(req_ready == !busy, "R6", "ready", req_ready, !busy);
      check(rsp_done == exp_done, "R3", "done", rsp_done, exp_done);
      if (busy) check(ram_addr == op_addr, "R7", "ram address", ram_addr, op_addr);
      if (e_dq) check(ram_dq_out == op_data, "R4", "write byte", ram_dq_out, op_data);
      if (exp_done && !op_wr) check(rsp_rdata == exp_rdata, "R3", "read byte", rsp_rdata, exp_rdata);
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] golden [int];

  task automatic do_req(input bit wr, input logic [20:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    n = 1;
    while (!rsp_done && n < 60) begin @(negedge clk); n++; end
    check(n == (wr ? W_END : R_DONE) + 1, "R8", wr ? "write latency" : "read latency",
          n, (wr ? W_END : R_DONE) + 1);
    if (wr) golden[int'(a)] = d;
    else check(rsp_rdata == (golden.exists(int'(a)) ? golden[int'(a)] : init_pat(a)), "R9",
               "read-back byte", rsp_rdata, golden.exists(int'(a)) ? golden[int'(a)] : init_pat(a));
  endtask

  task automatic run_tests();
    int n;
    repeat (4) @(negedge clk);
    // R1: outputs while reset is held
    check(ram_cs_n && ram_oe_n && ram_we_n, "R1", "strobes in reset",
          {ram_cs_n, ram_oe_n, ram_we_n}, 3'b111);
    check(!ram_dq_oe && !rsp_done && req_ready, "R1", "drive/done/ready in reset",
          {ram_dq_oe, rsp_done, req_ready}, 3'b001);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    check(ram_cs_n && ram_oe_n && ram_we_n && !ram_dq_oe && req_ready, "R1", "idle after reset",
          {ram_cs_n, ram_oe_n, ram_we_n, ram_dq_oe, req_ready}, 5'b11101);
    // R6: fields toggle with valid low, nothing may start
    for (int i = 0; i < 8; i++) begin
      req_write = 1; req_addr = 21'(i * 4099); req_wdata = 8'(i);
      @(negedge clk);
    end
    check(ram_cs_n && ram_we_n && !ram_dq_oe, "R6", "no cycle with valid low",
          {ram_cs_n, ram_we_n, ram_dq_oe}, 3'b110);
    // R9: read every bank before any write
    for (int b = 0; b < 4; b++) do_req(0, {2'(b), 19'h0ABCD ^ 19'(b)}, 8'h00);
    // R4/R9: write each bank, then read back
    for (int b = 0; b < 4; b++) do_req(1, {2'(b), 19'h01234 + 19'(b)}, 8'h11 * 8'(b + 1));
    for (int b = 3; b >= 0; b--) do_req(0, {2'(b), 19'h01234 + 19'(b)}, 8'h00);
    // R9: extreme addresses
    do_req(1, 21'h000000, 8'hA5);
    do_req(1, 21'h1FFFFF, 8'h5A);
    do_req(0, 21'h1FFFFF, 8'h00);
    do_req(0, 21'h000000, 8'h00);
    // R5: turnaround after a read, measured at the handshake
    do_req(0, 21'h0F0F0F, 8'h00);
    n = 0;
    while (!req_ready && n < 20) begin
      check(ram_cs_n && ram_oe_n && !ram_dq_oe, "R5", "bus quiet in turnaround",
            {ram_cs_n, ram_oe_n, ram_dq_oe}, 3'b110);
      @(negedge clk); n++;
    end
    check(n == B_TA, "R5", "turnaround cycles", n, B_TA);
    // read then write at once, write then read, two writes then read
    do_req(1, 21'h0F0F0F, 8'hC3);
    do_req(0, 21'h0F0F0F, 8'h00);
    do_req(1, 21'h155555, 8'h3C);
    do_req(1, 21'h155555, 8'h96);
    do_req(0, 21'h155555, 8'h00);
    do_req(0, 21'h0AAAAA, 8'h00);
    repeat (5) @(negedge clk);
    check(req_ready && ram_cs_n, "R6", "idle at end", {req_ready, ram_cs_n}, 2'b11);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        check(0, "R6", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule